// File: doc/BRIEF.md
# Monitor Interrupt Status Combiner

This block merges two kinds of interrupt sources into a single active-low interrupt line. The first kind is a set of voltage and fan channels. A conversion engine outside this block scans these channels in a round robin. When a full round finishes, it pulses `round_done` and presents, for every channel, whether the value sat above its upper limit or below its lower limit. The block records each out-of-window channel in a sticky status bit. Each status bit can be masked. Software clears the status bits by reading them.

The second kind is five external request lines. These lines keep no stored state. They are resynchronised and then feed the interrupt output directly for as long as they stay active and enabled. A global clear control in the control register silences the output whatever the sources are doing. Software configures the block through a simple byte-wide write port and reads it back through a read port with one cycle of latency.

The register map uses `NB = NUM_CH/8` status bytes. The byte addresses are:
- 0 to NB-1: status, cleared when read.
- NB to 2NB-1: status mirror, which does not clear.
- 2NB to 3NB-1: mask.
- 3NB: control. Bit 0 is the interrupt clear. Bit 7 disables the request-line group.
- 3NB+1: request-line enables, one bit per line.

Channel `c` lives in byte `c/8`, bit `c%8`. With the defaults, the addresses are 0, 1, 2, 3, 4, 5, 6 and 7.

Top module: `mic_combiner`

## Requirements
- R1: After reset, `int_n` is 1 and all status bits are 0. Every mask bit is 1, so each mask byte reads 0xFF. The control register reads 0x80 and the enable register reads 0x00.
- R2: On a cycle with `round_done` high, status bit c becomes set when `above_hi[c]` or `below_lo[c]` is 1. Without `round_done`, no status bit becomes set. A channel that is still out of limits on the next round after a read sets its bit again.
- R3: `int_n` is registered. It goes low on the edge after any status bit whose mask bit is 0 is set. A status bit whose mask bit is 1 does not pull `int_n` low.
- R4: A read at a status address returns that byte in `rd_data` and clears its bits. When `round_done` sets a bit in the same cycle as the read, that bit stays set. Once no unmasked source remains, `int_n` returns to 1 on the following edge.
- R5: A status bit stays set after its channel returns inside limits, and `int_n` stays low, until the bit is read.
- R6: A read at a mirror address (NB+b) returns the same value as status byte b and leaves the status unchanged.
- R7: Each request line passes through a two-flop synchroniser that resets to the line's inactive level. This puts `int_n` three edges after a change on the raw line. Lines 0 to 2 are active low and lines 3 and 4 are active high. A line pulls `int_n` low while it is active, its enable bit is 1 and control bit 7 is 0.
- R8: While control bit 0 is 1, `int_n` is 1 from the next edge onward, whatever the sources are.
- R9: Writes to the mask, control and enable addresses can be read back. Writes to status or mirror addresses change nothing.
- R10: `rd_data` updates on the edge after `rd_en` is high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| round_done | input | 1 | Pulse marking the end of a conversion round |
| above_hi | input | NUM_CH | Per-channel flag: value above the upper limit |
| below_lo | input | NUM_CH | Per-channel flag: value below the lower limit |
| irq_raw | input | NUM_IRQ | Asynchronous external request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Registered read data |
| int_n | output | 1 | Combined active-low interrupt |

## Verification
Several properties are checked by assertions on every cycle:
- No status bit rises without `round_done`.
- No bit falls without a status read.
- A mirror read leaves the status untouched.
- A status read empties its byte.
- The clear control and an all-masked, group-disabled state both hold `int_n` high.

Other behaviours can only be shown by the bench's scenarios, since they depend on sequences and exact latencies:
- Re-assertion on a following round.
- A bit set in the same cycle as a read surviving that read.
- The three-edge request-line latency with mixed polarities.
- Readback of the configuration registers.
- Rejection of writes to the status addresses.

// File: rtl/mic_pkg.sv
package mic_pkg;
  localparam int BYTE_W = 8;
  localparam int CTRL_CLR_BIT = 0;
  localparam int CTRL_GRPDIS_BIT = 7;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [2:0] {
    RK_STATUS,
    RK_MIRROR,
    RK_MASK,
    RK_CTRL,
    RK_IRQEN,
    RK_NONE
  } reg_kind_e;
endpackage

// File: rtl/mic_sync.sv
module mic_sync #(
  parameter int WIDTH = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mic_status_bank.sv
module mic_status_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              round_done,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] status
);
  logic [NUM_CH-1:0] set_gated;

  assign set_gated = round_done ? set_vec : '0;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_vec) | set_gated;
  end
endmodule

// File: rtl/mic_cfg_regs.sv
module mic_cfg_regs
  import mic_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int NUM_IRQ = 5,
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  byte_t              wr_data,
  output logic [NUM_CH-1:0]  mask,
  output logic               int_clr,
  output logic               grp_dis,
  output logic [NUM_IRQ-1:0] irq_en
);
  localparam int NB = NUM_CH / BYTE_W;
  localparam int MASK_BASE = 2 * NB;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(3 * NB);
  localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(3 * NB + 1);

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_mask
      always_ff @(posedge clk) begin
        if (rst) begin
          mask[b*BYTE_W +: BYTE_W] <= '1;
        end else if (wr_en && wr_addr == ADDR_W'(MASK_BASE + b)) begin
          mask[b*BYTE_W +: BYTE_W] <= wr_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      int_clr <= 1'b0;
      grp_dis <= 1'b1;
      irq_en  <= '0;
    end else if (wr_en) begin
      if (wr_addr == CTRL_ADDR) begin
        int_clr <= wr_data[CTRL_CLR_BIT];
        grp_dis <= wr_data[CTRL_GRPDIS_BIT];
      end
      if (wr_addr == EN_ADDR) irq_en <= wr_data[NUM_IRQ-1:0];
    end
  end
endmodule

// File: rtl/mic_combiner.sv
module mic_combiner
  import mic_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int NUM_IRQ = 5,
  parameter int NUM_LOW_IRQ = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               round_done,
  input  logic [NUM_CH-1:0]  above_hi,
  input  logic [NUM_CH-1:0]  below_lo,
  input  logic [NUM_IRQ-1:0] irq_raw,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [7:0]         rd_data,
  output logic               int_n
);
  localparam int NB = NUM_CH / BYTE_W;
  localparam int MIR_BASE = NB;
  localparam int MASK_BASE = 2 * NB;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(3 * NB);
  localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(3 * NB + 1);
  localparam logic [NUM_IRQ-1:0] IDLE_LVL = NUM_IRQ'((1 << NUM_LOW_IRQ) - 1);

  logic [NUM_CH-1:0]  status_q;
  logic [NUM_CH-1:0]  mask_q;
  logic [NUM_CH-1:0]  clr_vec;
  logic [NUM_IRQ-1:0] irq_sync;
  logic [NUM_IRQ-1:0] irq_act;
  logic [NUM_IRQ-1:0] irq_en;
  logic               int_clr;
  logic               grp_dis;
  logic               stat_hit;
  logic               irq_hit;
  byte_t              rd_next;

  mic_sync #(
    .WIDTH(NUM_IRQ), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)
  ) u_sync (
    .clk(clk), .rst(rst), .d(irq_raw), .q(irq_sync)
  );

  mic_cfg_regs #(
    .NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mask(mask_q), .int_clr(int_clr),
    .grp_dis(grp_dis), .irq_en(irq_en)
  );

  genvar b, i;
  generate
    for (b = 0; b < NB; b++) begin : g_clr
      assign clr_vec[b*BYTE_W +: BYTE_W] =
        {BYTE_W{rd_en && rd_addr == ADDR_W'(b)}};
    end
    for (i = 0; i < NUM_IRQ; i++) begin : g_pol
      if (i < NUM_LOW_IRQ) begin : g_low
        assign irq_act[i] = ~irq_sync[i];
      end else begin : g_high
        assign irq_act[i] = irq_sync[i];
      end
    end
  endgenerate

  mic_status_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst(rst), .round_done(round_done),
    .set_vec(above_hi | below_lo), .clr_vec(clr_vec), .status(status_q)
  );

  // Read selection: status and mirror share data, only status clears.
  function automatic reg_kind_e decode(input logic [ADDR_W-1:0] a);
    decode = RK_NONE;
    for (int k = 0; k < NB; k++) begin
      if (a == ADDR_W'(k))             decode = RK_STATUS;
      if (a == ADDR_W'(MIR_BASE + k))  decode = RK_MIRROR;
      if (a == ADDR_W'(MASK_BASE + k)) decode = RK_MASK;
    end
    if (a == CTRL_ADDR) decode = RK_CTRL;
    if (a == EN_ADDR)   decode = RK_IRQEN;
  endfunction

  always_comb begin
    rd_next = '0;
    unique case (decode(rd_addr))
      RK_STATUS, RK_MIRROR: begin
        for (int k = 0; k < NB; k++) begin
          if (rd_addr == ADDR_W'(k) || rd_addr == ADDR_W'(MIR_BASE + k))
            rd_next = status_q[k*BYTE_W +: BYTE_W];
        end
      end
      RK_MASK: begin
        for (int k = 0; k < NB; k++) begin
          if (rd_addr == ADDR_W'(MASK_BASE + k))
            rd_next = mask_q[k*BYTE_W +: BYTE_W];
        end
      end
      RK_CTRL: begin
        rd_next[CTRL_CLR_BIT]    = int_clr;
        rd_next[CTRL_GRPDIS_BIT] = grp_dis;
      end
      RK_IRQEN: rd_next = BYTE_W'(irq_en);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  assign stat_hit = |(status_q & ~mask_q);
  assign irq_hit  = !grp_dis && |(irq_act & irq_en);

  always_ff @(posedge clk) begin
    if (rst) int_n <= 1'b1;
    else     int_n <= !((stat_hit || irq_hit) && !int_clr);
  end
endmodule

// File: rtl/mic_combiner_chk.sv
module mic_combiner_chk #(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              round_done,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              int_n,
  input logic [NUM_CH-1:0] status,
  input logic [NUM_CH-1:0] mask,
  input logic              clr_ctrl,
  input logic              grp_dis
);
  localparam int NB = NUM_CH / 8;

  logic stat_rd;
  logic mir_rd;
  assign stat_rd = rd_en && (rd_addr < ADDR_W'(NB));
  assign mir_rd  = rd_en && (rd_addr >= ADDR_W'(NB)) && (rd_addr < ADDR_W'(2 * NB));

  AST_NO_SET_WITHOUT_ROUND: assert property (@(posedge clk) disable iff (rst)
    !round_done |=> ((status & ~$past(status)) == '0)); // R2

  AST_STICKY_UNTIL_READ: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> ((status & $past(status)) == $past(status))); // R5

  AST_MIRROR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (mir_rd && !round_done) |=> (status == $past(status))); // R6

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == '0 && !round_done) |=> (status[7:0] == 8'h00)); // R4

  AST_CLEAR_SILENCES: assert property (@(posedge clk) disable iff (rst)
    clr_ctrl |=> int_n); // R8

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (grp_dis && ((status & ~mask) == '0)) |=> int_n); // R3
endmodule

bind mic_combiner mic_combiner_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .round_done(round_done), .rd_en(rd_en),
  .rd_addr(rd_addr), .int_n(int_n), .status(status_q), .mask(mask_q),
  .clr_ctrl(int_clr), .grp_dis(grp_dis)
);

// File: tb/mic_combiner_test.sv
`timescale 1ns/1ps
module mic_combiner_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        round_done = 1'b0;
  logic [15:0] above_hi = '0;
  logic [15:0] below_lo = '0;
  logic [4:0]  irq_raw = 5'b00111;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        int_n;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mic_combiner uut (
    .clk(clk), .rst(rst), .round_done(round_done), .above_hi(above_hi),
    .below_lo(below_lo), .irq_raw(irq_raw), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .int_n(int_n)
  );

  // Behavioural reference model, advanced on every rising edge.
  logic [15:0] m_stat, m_mask;
  logic [7:0]  m_ctrl, m_rd;
  logic [4:0]  m_en, m_s1, m_s2;
  logic        m_int_n;

  always @(posedge clk) begin
    bit want;
    logic [15:0] clr;
    if (rst) begin
      m_stat = '0; m_mask = 16'hFFFF; m_ctrl = 8'h80; m_en = '0;
      m_s1 = 5'b00111; m_s2 = 5'b00111; m_int_n = 1'b1; m_rd = '0;
    end else begin
      want = 0;
      for (int i = 0; i < 5; i++) begin
        bit act;
        act = (i < 3) ? !m_s2[i] : m_s2[i];
        if (act && m_en[i] && !m_ctrl[7]) want = 1;
      end
      if ((m_stat & ~m_mask) != 0) want = 1;
      if (m_ctrl[0]) want = 0;
      clr = '0;
      if (rd_en) begin
        case (rd_addr)
          0: begin m_rd = m_stat[7:0];  clr = 16'h00FF; end
          1: begin m_rd = m_stat[15:8]; clr = 16'hFF00; end
          2: m_rd = m_stat[7:0];
          3: m_rd = m_stat[15:8];
          4: m_rd = m_mask[7:0];
          5: m_rd = m_mask[15:8];
          6: m_rd = m_ctrl;
          7: m_rd = {3'b000, m_en};
          default: m_rd = 8'h00;
        endcase
      end
      if (wr_en) begin
        case (wr_addr)
          4: m_mask[7:0]  = wr_data;
          5: m_mask[15:8] = wr_data;
          6: m_ctrl = wr_data & 8'h81;
          7: m_en = wr_data[4:0];
          default: ;
        endcase
      end
      m_stat = (m_stat & ~clr) | (round_done ? (above_hi | below_lo) : 16'h0);
      m_s2 = m_s1;
      m_s1 = irq_raw;
      m_int_n = !want;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (int_n !== m_int_n) begin
        failures++;
        $display("FAIL R3 int_n per-cycle actual=%b expected=%b t=%0t", int_n, m_int_n, $time);
      end
      checks++;
      if (rd_data !== m_rd) begin
        failures++;
        $display("FAIL R10 rd_data per-cycle actual=%h expected=%h t=%0t", rd_data, m_rd, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic round(input logic [15:0] hi, input logic [15:0] lo);
    round_done = 1; above_hi = hi; below_lo = lo;
    @(negedge clk);
    round_done = 0; above_hi = '0; below_lo = '0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    tick(3);
    rst = 0;
    tick(1);
    // R1 reset state
    chk("R1 int_n", {7'b0, int_n}, 8'h01);
    rd(4, v); chk("R1 mask0", v, 8'hFF);
    rd(5, v); chk("R1 mask1", v, 8'hFF);
    rd(6, v); chk("R1 ctrl", v, 8'h80);
    rd(7, v); chk("R1 irqen", v, 8'h00);
    rd(2, v); chk("R1 status", v, 8'h00);

    // R3, R5, R6, R4: unmasked channel 0
    wr(4, 8'hFE);
    round(16'h0001, 16'h0000); tick(1);
    chk("R3 int low", {7'b0, int_n}, 8'h00);
    round(16'h0000, 16'h0000); tick(1);
    rd(2, v); chk("R6 mirror", v, 8'h01);
    chk("R5 still low", {7'b0, int_n}, 8'h00);
    rd(2, v); chk("R5 mirror kept", v, 8'h01);
    rd(0, v); chk("R4 read value", v, 8'h01);
    tick(1);
    chk("R4 int released", {7'b0, int_n}, 8'h01);
    rd(2, v); chk("R4 cleared", v, 8'h00);

    // R2 re-set on next round
    round(16'h0000, 16'h0001); tick(1);
    chk("R2 reassert", {7'b0, int_n}, 8'h00);
    rd(0, v); tick(1);
    tick(1);
    round(16'h0000, 16'h0000); tick(1);
    chk("R2 no set in range", {7'b0, int_n}, 8'h01);

    // R3 masked channel 9
    round(16'h0200, 16'h0000); tick(1);
    chk("R3 masked quiet", {7'b0, int_n}, 8'h01);
    rd(3, v); chk("R3 masked status", v, 8'h02);
    rd(1, v); tick(1);

    // R9 writes to status/mirror ignored, config readback
    round(16'h0400, 16'h0000); tick(1);
    wr(1, 8'h00); wr(3, 8'h00); wr(0, 8'hFF);
    rd(3, v); chk("R9 status write ignored", v, 8'h04);
    rd(2, v); chk("R9 status0 write ignored", v, 8'h00);
    rd(4, v); chk("R9 mask readback", v, 8'hFE);
    rd(1, v); tick(1);

    // R4 read and round in same cycle
    rd_en = 1; rd_addr = 0; round_done = 1; above_hi = 16'h0001;
    @(negedge clk);
    rd_en = 0; round_done = 0; above_hi = '0;
    chk("R4 same-cycle old value", rd_data, 8'h00);
    rd(2, v); chk("R4 same-cycle survives", v, 8'h01);

    // R8 global clear
    tick(1);
    chk("R8 pending low", {7'b0, int_n}, 8'h00);
    wr(6, 8'h81); tick(1);
    chk("R8 forced high", {7'b0, int_n}, 8'h01);
    rd(6, v); chk("R9 ctrl readback", v, 8'h81);
    wr(6, 8'h80); tick(1);
    chk("R8 released", {7'b0, int_n}, 8'h00);
    rd(0, v); tick(2);

    // R7 request lines
    wr(7, 8'h1F); wr(6, 8'h00); tick(3);
    chk("R7 idle lines", {7'b0, int_n}, 8'h01);
    irq_raw = 5'b00101; tick(2);
    chk("R7 latency not yet", {7'b0, int_n}, 8'h01);
    tick(1);
    chk("R7 low line active", {7'b0, int_n}, 8'h00);
    irq_raw = 5'b00111; tick(3);
    chk("R7 low line idle", {7'b0, int_n}, 8'h01);
    irq_raw = 5'b10111; tick(3);
    chk("R7 high line active", {7'b0, int_n}, 8'h00);
    wr(7, 8'h0F); tick(1);
    chk("R7 line disabled", {7'b0, int_n}, 8'h01);
    wr(7, 8'h1F); tick(1);
    chk("R7 line enabled", {7'b0, int_n}, 8'h00);
    wr(6, 8'h80); tick(1);
    chk("R7 group disabled", {7'b0, int_n}, 8'h01);
    irq_raw = 5'b00111;

    // R10 hold without read
    rd(7, v);
    tick(3);
    chk("R10 held", rd_data, 8'h1F);

    tick(4);
    finish_run();
  end
endmodule